// File: doc/BRIEF.md
# Sequential Repeated-Addition Multiplier

This block forms the unsigned product of two 32-bit operands over many clock cycles. It does not use shift-and-add. It keeps a down-counter `x`, loaded with the first operand. It keeps a fixed addend `y`, loaded with the second operand. It keeps an accumulator `z`, cleared to zero. Each pass through the loop first tests `x` for zero. If `x` is not zero, the pass decrements `x` and adds `y` into `z`. Throughout the run, `x*y + z` equals the product of the two latched operands, modulo 2^32. When `x` reaches zero the accumulator holds the result. The run time therefore grows in fixed steps with the first operand, and the second operand has no effect on it.

The block models a fixed per-pass cost of `ITER` clocks (default 7). This matches a small counting loop on a simple in-order core. A built-in cycle counter reports how many clocks each multiplication took. The caller waits for `ready_o`, pulses `start_i` together with both operands, and then waits for the one-cycle `done_o` pulse. The product and the cycle count stay on their outputs until the next completion.

Top module: `repadd_mul`

## Requirements
- R1: After synchronous reset, `ready_o` is 1 and `done_o` is 0. `product_o` and `cycles_o` are both 0.
- R2: A start is accepted on a clock edge where `start_i` and `ready_o` are both 1. Both operands are captured on that edge, and `ready_o` is 0 in the following cycle.
- R3: The result on `product_o` equals (a*b) mod 2^32. An overflow wraps silently and raises no flag.
- R4: `done_o` is high for exactly one cycle, and `ready_o` is high in that same cycle. `product_o` and `cycles_o` keep their values until the next `done_o`.
- R5: `done_o` rises exactly `ITER*a + 1` clock edges after the accepting edge. The value of b does not change this latency.
- R6: With a = 0, `done_o` rises one edge after acceptance and `product_o` is 0.
- R7: While `ready_o` is 0, `start_i` and any change on the operand inputs are ignored. The running result is unaffected, and no extra run follows.
- R8: When `done_o` is high, `cycles_o` equals the number of clock edges from acceptance to completion, `ITER*a + 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, honoured only while ready |
| opa_i | input | W | First operand (iteration count) |
| opb_i | input | W | Second operand (addend) |
| ready_o | output | 1 | Idle and able to accept a start |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | W | Wrapped product, held until next completion |
| cycles_o | output | CW | Clocks taken by the last multiplication |

## Verification
On every cycle, the bound checker tracks the operands it saw accepted. While the unit is busy, it checks that `x*y + z` equals their product modulo 2^32 and that the addend stays still. At each completion it checks the product, the cycle count, the pulse shape and the return of ready. Only the bench scenarios can show the exact latency measured from the handshake for each a. They also show that latency is equal for different b with the same a. Finally, they show that a start or operand change issued mid-run leaves the result unchanged and never launches a second run.

// File: rtl/repadd_mul_pkg.sv
package repadd_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TEST = 2'd1,
    ST_HOLD = 2'd2
  } mul_state_t;
endpackage

// File: rtl/repadd_mul_ctrl.sv
module repadd_mul_ctrl
  import repadd_mul_pkg::*;
#(
  parameter int ITER = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic x_zero_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic ready_o
);
  localparam int PH_W = (ITER > 2) ? $clog2(ITER - 1) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'((ITER >= 2) ? (ITER - 2) : 0);
  localparam bit SINGLE = (ITER <= 1);

  mul_state_t state_q, state_d;
  logic [PH_W-1:0] ph_q;
  logic ready_q;

  always_comb begin
    state_d  = state_q;
    load_o   = 1'b0;
    step_o   = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_TEST;
        end
      end
      ST_TEST: begin
        if (x_zero_i) begin
          finish_o = 1'b1;
          state_d  = ST_IDLE;
        end else if (SINGLE) begin
          step_o = 1'b1;
        end else begin
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (ph_q == PH_LAST) begin
          step_o  = 1'b1;
          state_d = ST_TEST;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      ready_q <= 1'b1;
    end else begin
      state_q <= state_d;
      ready_q <= (state_d == ST_IDLE);
      if (state_q == ST_HOLD) ph_q <= ph_q + 1'b1;
      else                    ph_q <= '0;
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/repadd_mul_dp.sv
module repadd_mul_dp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         x_zero_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] z_o
);
  logic [W-1:0] x_q, y_q, z_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (load_i) begin
      x_q <= opa_i;
      y_q <= opb_i;
      z_q <= '0;
    end else if (step_i) begin
      x_q <= x_q - 1'b1;
      z_q <= z_q + y_q;
    end
  end

  assign x_zero_o = (x_q == '0);
  assign x_o = x_q;
  assign y_o = y_q;
  assign z_o = z_q;
endmodule

// File: rtl/repadd_mul_cyc.sv
module repadd_mul_cyc #(
  parameter int CW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          busy_i,
  input  logic          finish_i,
  output logic [CW-1:0] cycles_o
);
  logic [CW-1:0] cnt_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      if (load_i)      cnt_q <= '0;
      else if (busy_i) cnt_q <= cnt_q + 1'b1;
      if (finish_i)    last_q <= cnt_q + 1'b1;
    end
  end

  assign cycles_o = last_q;
endmodule

// File: rtl/repadd_mul.sv
module repadd_mul #(
  parameter int W    = 32,
  parameter int CW   = 40,
  parameter int ITER = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [W-1:0]  product_o,
  output logic [CW-1:0] cycles_o
);
  logic load_w, step_w, finish_w, x_zero_w, ready_w;
  logic [W-1:0] x_w, y_w, z_w;
  logic done_q;
  logic [W-1:0] prod_q;

  repadd_mul_ctrl #(.ITER(ITER)) ctrl_i (
    .clk(clk), .rst(rst), .start_i(start_i), .x_zero_i(x_zero_w),
    .load_o(load_w), .step_o(step_w), .finish_o(finish_w), .ready_o(ready_w)
  );

  repadd_mul_dp #(.W(W)) dp_i (
    .clk(clk), .rst(rst), .load_i(load_w), .step_i(step_w),
    .opa_i(opa_i), .opb_i(opb_i), .x_zero_o(x_zero_w),
    .x_o(x_w), .y_o(y_w), .z_o(z_w)
  );

  repadd_mul_cyc #(.CW(CW)) cyc_i (
    .clk(clk), .rst(rst), .load_i(load_w), .busy_i(!ready_w),
    .finish_i(finish_w), .cycles_o(cycles_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      prod_q <= '0;
    end else begin
      done_q <= finish_w;
      if (finish_w) prod_q <= z_w;
    end
  end

  assign ready_o   = ready_w;
  assign done_o    = done_q;
  assign product_o = prod_q;
endmodule

// File: rtl/repadd_mul_chk.sv
module repadd_mul_chk #(
  parameter int W    = 32,
  parameter int CW   = 40,
  parameter int ITER = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [W-1:0]  opa_i,
  input logic [W-1:0]  opb_i,
  input logic          ready_o,
  input logic          done_o,
  input logic [W-1:0]  product_o,
  input logic [CW-1:0] cycles_o,
  input logic [W-1:0]  x_q,
  input logic [W-1:0]  y_q,
  input logic [W-1:0]  z_q
);
  logic [W-1:0] a_cap, b_cap;
  logic [W-1:0] want_prod, now_sum;
  logic [CW-1:0] want_cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cap <= '0;
      b_cap <= '0;
    end else if (start_i && ready_o) begin
      a_cap <= opa_i;
      b_cap <= opb_i;
    end
  end

  assign want_prod = a_cap * b_cap;
  assign now_sum   = x_q * y_q + z_q;
  assign want_cyc  = CW'(ITER) * CW'(a_cap) + CW'(1);

  a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (start_i && ready_o) |=> (!ready_o && !done_o));

  a_r3_invariant: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> (now_sum == want_prod));

  a_r3_product: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (product_o == want_prod));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r4_ready_with_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ready_o);

  a_r7_addend_frozen: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> $stable(y_q));

  a_r8_cycle_count: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cycles_o == want_cyc));
endmodule

bind repadd_mul repadd_mul_chk #(.W(W), .CW(CW), .ITER(ITER)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .opa_i(opa_i), .opb_i(opb_i),
  .ready_o(ready_o), .done_o(done_o), .product_o(product_o),
  .cycles_o(cycles_o), .x_q(x_w), .y_q(y_w), .z_q(z_w)
);

// File: tb/repadd_mul_tb_top.sv
module repadd_mul_tb_top;
  localparam int W = 32;
  localparam int CW = 40;
  localparam int ITER = 7;
  localparam int NV = 10;
  localparam logic [NV-1:0][3*W-1:0] VEC = '{
    {32'd3,  32'd5,          32'd15},
    {32'd0,  32'd77,         32'd0},
    {32'd1,  32'hFFFF_FFFF,  32'hFFFF_FFFF},
    {32'd2,  32'h8000_0001,  32'h0000_0002},
    {32'd6,  32'd123,        32'd738},
    {32'd5,  32'd123,        32'd615},
    {32'd5,  32'd1,          32'd5},
    {32'd4,  32'd0,          32'd0},
    {32'd10, 32'h2000_0000,  32'h4000_0000},
    {32'd7,  32'h7FFF_FFFF,  32'h7FFF_FFF9}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [W-1:0] opa_i = '0, opb_i = '0;
  logic ready_o, done_o;
  logic [W-1:0] product_o;
  logic [CW-1:0] cycles_o;
  int n_chk = 0;
  int n_bad = 0;
  int lat_b123 = -1;

  always #4 clk = ~clk;

  repadd_mul #(.W(W), .CW(CW), .ITER(ITER)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .opa_i(opa_i), .opb_i(opb_i),
    .ready_o(ready_o), .done_o(done_o), .product_o(product_o), .cycles_o(cycles_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Runs one multiplication; optionally disturbs inputs mid-run (R7).
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] exp_p, input bit disturb, output int lat);
    int k;
    @(negedge clk);
    start_i = 1'b1; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 ready low after accept", 64'(ready_o), 64'd0);
    k = 1;
    while (!done_o && k < 1000) begin
      if (disturb && k == 2) begin
        start_i = 1'b1; opa_i = 32'd9; opb_i = 32'd9;
      end else if (disturb && k == 3) begin
        start_i = 1'b0; opa_i = 32'd1; opb_i = 32'd2;
      end
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    lat = k - 1;
    check("R5 latency", 64'(lat), 64'(ITER * a + 1));
    check("R3 product", 64'(product_o), 64'(exp_p));
    check("R8 cycle count", 64'(cycles_o), 64'(ITER * a + 1));
    check("R4 ready with done", 64'(ready_o), 64'd1);
    @(negedge clk);
    check("R4 done one cycle", 64'(done_o), 64'd0);
    check("R4 product held", 64'(product_o), 64'(exp_p));
    if (a == 0) check("R6 zero operand product", 64'(product_o), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check("R1 ready after reset", 64'(ready_o), 64'd1);
    check("R1 done after reset", 64'(done_o), 64'd0);
    check("R1 product after reset", 64'(product_o), 64'd0);
    check("R1 cycles after reset", 64'(cycles_o), 64'd0);
    rst = 1'b0;

    for (int i = NV - 1; i >= 0; i--) begin
      run_op(VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0, lat);
      if (VEC[i][3*W-1:2*W] == 32'd5) begin
        if (lat_b123 < 0) lat_b123 = lat;
        else check("R5 latency independent of b", 64'(lat), 64'(lat_b123));
      end
    end

    // R6: a = 0 completes after one edge
    run_op(32'd0, 32'hDEAD_BEEF, 32'd0, 1'b0, lat);
    check("R6 zero operand latency", 64'(lat), 64'd1);

    // R7: start and operand changes while busy are ignored
    run_op(32'd3, 32'd5, 32'd15, 1'b1, lat);
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (done_o || !ready_o) begin
        check("R7 no extra run", 64'({done_o, ready_o}), 64'b01);
        break;
      end
    end
    check("R7 result kept", 64'(product_o), 64'd15);
    check("R7 cycles kept", 64'(cycles_o), 64'(ITER * 3 + 1));

    // R3: wrap on overflow
    run_op(32'd3, 32'h8000_0000, 32'h8000_0000, 1'b0, lat);

    // R1: reset mid-run returns to idle state
    @(negedge clk);
    start_i = 1'b1; opa_i = 32'd4; opb_i = 32'd4;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 ready after mid-run reset", 64'(ready_o), 64'd1);
    check("R1 product after mid-run reset", 64'(product_o), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    summary();
  end
endmodule